// File: doc/BRIEF.md
# Caption and Widescreen Byte Register Bank

This block is the host-facing store for the closed-caption and widescreen-signalling (WSS) bytes that a video decoder's data slicer pulls out of the vertical blanking interval. The slicer presents one byte per strobe. Each strobe is tagged with the field (odd or even), the source (caption or WSS), the byte position (first or second) and the line it came from. The bank keeps one two-byte pair for each field/source combination, four pairs in all. It raises a new-data flag for a pair when the second byte of that pair lands.

A host reads the bank through a simple sub-addressed register port. It can also start a self-timed software reset, which drives a fixed-length reset pulse to the rest of the device. A flag drops when the host reads the second byte of its pair. A flag also drops when the ancillary-data formatter signals that it has shipped that pair in the video stream.

Pair index p is {source, field}: source 0 = caption, 1 = WSS; field 0 = odd, 1 = even.

Top module: `capbank_regs`

## Requirements
- R1: After the external reset, every data register reads 80h and the control register (1Fh) reads 00h.
- R2: An accepted load writes ld_byte into pair p = {ld_src, ld_field}. The first byte (ld_hi=0) goes to register A at sub-address 20h+2p, and the second byte (ld_hi=1) goes to register B at 21h+2p. Bit 0 of each register holds the first bit received.
- R3: A caption load (ld_src=0) is accepted only when the enable for its field is high and ld_line is 18, 21 or 22 (odd field) or 281, 284 or 335 (even field). A WSS load (ld_src=1) is accepted with any line and any enable.
- R4: An accepted second-byte load sets the flag of its pair at the next clock edge. Flag p reads at bit p of the control register.
- R5: A host read (h_rd) of register B of a pair clears that pair's flag. A read of register A leaves the flag unchanged.
- R6: A consume strobe (anc_take) with anc_sel = p clears flag p.
- R7: When a set and a clear of the same flag fall in the same cycle, the flag ends up set.
- R8: Host writes to the data registers, and to control bits other than bit 7, change nothing.
- R9: Writing 1 to control bit 7 while no reset is running drives soft_rst_o high for exactly 4 cycles, starting the cycle after the write. Control bit 7 reads 1 while the pulse runs. A second such write during the pulse does not lengthen it.
- R10: While soft_rst_o is high, every data register and flag returns to its R1 value, and loads are discarded.
- R11: Reads of sub-addresses outside 1Fh..27h return 00h. Control bits 6..4 read 0.
- R12: h_rdata is combinational from h_addr and shows the register contents before any update at the coming clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | External asynchronous reset, active low |
| ld_valid | input | 1 | Slicer byte strobe |
| ld_field | input | 1 | 0 = odd field, 1 = even field |
| ld_src | input | 1 | 0 = caption, 1 = WSS |
| ld_hi | input | 1 | 0 = first byte (A), 1 = second byte (B) |
| ld_line | input | 9 | Line number of the sliced byte |
| ld_byte | input | 8 | Sliced byte |
| cc_en_odd | input | 1 | Caption capture enable, odd field |
| cc_en_even | input | 1 | Caption capture enable, even field |
| anc_take | input | 1 | Pair sent as ancillary data |
| anc_sel | input | 2 | Pair index sent |
| h_wr | input | 1 | Host write strobe |
| h_rd | input | 1 | Host read strobe |
| h_addr | input | 8 | Host sub-address |
| h_wdata | input | 8 | Host write data |
| h_rdata | output | 8 | Host read data |
| soft_rst_o | output | 1 | Software reset pulse to the device |

## Verification
The bench targets the same-cycle collision of a second-byte load with a B read or a consume strobe. A design that lets the clear win would lose a fresh capture, and the flag would read 0. It reads register A alone, which must leave the flag set, and it feeds caption bytes on rejected lines or with the enable low, which a loose line decode would store. It also writes reset again during a running pulse, where a reloading counter would stretch soft_rst_o past 4 cycles, and it loads bytes during the pulse, which must not survive it.

// File: rtl/capbank_pkg.sv
package capbank_pkg;
  localparam int unsigned NPAIR = 4;

  typedef enum logic {SRC_CC = 1'b0, SRC_WSS = 1'b1} src_e;

  // Caption lines that may carry data, per field.
  function automatic logic cc_line_ok(input logic field, input logic [8:0] line);
    if (!field) return (line == 9'd18) || (line == 9'd21) || (line == 9'd22);
    return (line == 9'd281) || (line == 9'd284) || (line == 9'd335);
  endfunction

  // Sub-address of byte hi of pair p, counted from the data base.
  function automatic logic [7:0] pair_addr(input logic [7:0] base, input int p, input logic hi);
    return base + 8'(2 * p) + {7'd0, hi};
  endfunction
endpackage

// File: rtl/capbank_slot.sv
module capbank_slot #(
  parameter int unsigned DW = 8,
  parameter logic [DW-1:0] RST_VAL = 8'h80
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          srst,
  input  logic          ld_a,
  input  logic          ld_b,
  input  logic [DW-1:0] din,
  input  logic          clr,
  output logic [DW-1:0] reg_a,
  output logic [DW-1:0] reg_b,
  output logic          flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_a <= RST_VAL;
      reg_b <= RST_VAL;
      flag  <= 1'b0;
    end else if (srst) begin
      reg_a <= RST_VAL;
      reg_b <= RST_VAL;
      flag  <= 1'b0;
    end else begin
      if (ld_a) reg_a <= din;
      if (ld_b) reg_b <= din;
      // set has priority over clear
      if (ld_b)     flag <= 1'b1;
      else if (clr) flag <= 1'b0;
    end
  end
endmodule

// File: rtl/capbank_swrst.sv
module capbank_swrst #(
  parameter int unsigned PULSE = 4,
  localparam int unsigned CW = $clog2(PULSE + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  output logic busy
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
    else if (trig)        cnt <= CW'(PULSE);
  end

  assign busy = (cnt != '0);
endmodule

// File: rtl/capbank_regs.sv
module capbank_regs
  import capbank_pkg::*;
#(
  parameter int unsigned DW        = 8,
  parameter int unsigned LINE_W    = 9,
  parameter int unsigned AW        = 8,
  parameter logic [AW-1:0] CTRL_ADDR = 8'h1F,
  parameter logic [AW-1:0] DATA_BASE = 8'h20,
  parameter logic [DW-1:0] DATA_RST  = 8'h80,
  parameter int unsigned SRST_CYC  = 4,
  localparam int unsigned SELW     = $clog2(NPAIR),
  localparam int unsigned NDATA    = 2 * NPAIR
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_valid,
  input  logic              ld_field,
  input  logic              ld_src,
  input  logic              ld_hi,
  input  logic [LINE_W-1:0] ld_line,
  input  logic [DW-1:0]     ld_byte,
  input  logic              cc_en_odd,
  input  logic              cc_en_even,
  input  logic              anc_take,
  input  logic [SELW-1:0]   anc_sel,
  input  logic              h_wr,
  input  logic              h_rd,
  input  logic [AW-1:0]     h_addr,
  input  logic [DW-1:0]     h_wdata,
  output logic [DW-1:0]     h_rdata,
  output logic              soft_rst_o
);
  // Named internal events, visible to the checker.
  logic                 ld_accept;
  logic [NPAIR-1:0]     w_set;
  logic [NPAIR-1:0]     w_clr;
  logic [NPAIR-1:0]     w_ld_any;
  logic [NPAIR-1:0]     w_flag;
  logic [NPAIR-1:0][2*DW-1:0] w_data;
  logic                 srst_trig;
  logic [SELW-1:0]      ld_pair;
  logic                 field_en;

  assign ld_pair   = SELW'({ld_src, ld_field});
  assign field_en  = ld_field ? cc_en_even : cc_en_odd;
  assign ld_accept = ld_valid &&
                     ((ld_src == SRC_WSS) || (field_en && cc_line_ok(ld_field, ld_line)));
  assign srst_trig = h_wr && (h_addr == CTRL_ADDR) && h_wdata[7];

  capbank_swrst #(.PULSE(SRST_CYC)) u_swrst (
    .clk   (clk),
    .rst_n (rst_n),
    .trig  (srst_trig),
    .busy  (soft_rst_o)
  );

  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    logic hit;
    logic ld_a;
    logic [DW-1:0] ra;
    logic [DW-1:0] rb;
    assign hit  = ld_accept && (ld_pair == SELW'(p));
    assign ld_a = hit && !ld_hi;
    assign w_set[p]    = hit && ld_hi;
    assign w_ld_any[p] = hit;
    assign w_clr[p] = (h_rd && (h_addr == pair_addr(DATA_BASE, p, 1'b1))) ||
                      (anc_take && (anc_sel == SELW'(p)));

    capbank_slot #(.DW(DW), .RST_VAL(DATA_RST)) u_slot (
      .clk   (clk),
      .rst_n (rst_n),
      .srst  (soft_rst_o),
      .ld_a  (ld_a),
      .ld_b  (w_set[p]),
      .din   (ld_byte),
      .clr   (w_clr[p]),
      .reg_a (ra),
      .reg_b (rb),
      .flag  (w_flag[p])
    );
    assign w_data[p] = {rb, ra};
  end

  // Read multiplexer; writes to data and status never reach storage.
  always_comb begin
    h_rdata = '0;
    if (h_addr == CTRL_ADDR) begin
      h_rdata[7]         = soft_rst_o;
      h_rdata[NPAIR-1:0] = w_flag;
    end else begin
      for (int i = 0; i < NDATA; i++) begin
        if (h_addr == DATA_BASE + AW'(i))
          h_rdata = (i % 2 == 1) ? w_data[i/2][2*DW-1:DW] : w_data[i/2][DW-1:0];
      end
    end
  end
endmodule

// File: rtl/capbank_chk.sv
module capbank_chk #(
  parameter int unsigned DW = 8,
  parameter int unsigned AW = 8,
  parameter int unsigned NPAIR = 4,
  parameter int unsigned SRST_CYC = 4,
  parameter logic [AW-1:0] CTRL_ADDR = 8'h1F,
  parameter logic [AW-1:0] DATA_BASE = 8'h20
) (
  input logic clk,
  input logic rst_n,
  input logic soft_rst_o,
  input logic [AW-1:0] h_addr,
  input logic [DW-1:0] h_rdata,
  input logic [NPAIR-1:0] w_set,
  input logic [NPAIR-1:0] w_clr,
  input logic [NPAIR-1:0] w_ld_any,
  input logic [NPAIR-1:0] w_flag,
  input logic [NPAIR-1:0][2*DW-1:0] w_data
);
  logic [15:0] run_len;
  logic        mapped;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          run_len <= '0;
    else if (soft_rst_o) run_len <= run_len + 1'b1;
    else                 run_len <= '0;
  end

  assign mapped = (h_addr == CTRL_ADDR) ||
                  ((h_addr >= DATA_BASE) && (h_addr < DATA_BASE + AW'(2 * NPAIR)));

  // R9: pulse length fixed, not stretched by repeated writes
  p_pulse_len_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(soft_rst_o) |-> (run_len == 16'(SRST_CYC)));

  // R10: every flag is down after a reset cycle
  p_srst_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst_o |=> (w_flag == '0));

  // R11: unmapped reads return zero
  p_unmapped_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !mapped |-> (h_rdata == '0));

  // R11: reserved control bits read zero
  p_ctrl_reserved_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (h_addr == CTRL_ADDR) |-> (h_rdata[6:NPAIR] == '0));

  for (genvar p = 0; p < NPAIR; p++) begin : g_p
    // R4 and R7: an accepted second byte always leaves its flag set
    p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (w_set[p] && !soft_rst_o) |=> w_flag[p]);
    // R5 and R6: a clear without a set drops the flag
    p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (w_clr[p] && !w_set[p]) |=> !w_flag[p]);
    // R8: data only moves on a load or a reset
    p_data_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!w_ld_any[p] && !soft_rst_o) |=> $stable(w_data[p]));
  end
endmodule

bind capbank_regs capbank_chk #(
  .DW(DW), .AW(AW), .NPAIR(capbank_pkg::NPAIR), .SRST_CYC(SRST_CYC),
  .CTRL_ADDR(CTRL_ADDR), .DATA_BASE(DATA_BASE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .soft_rst_o(soft_rst_o),
  .h_addr(h_addr), .h_rdata(h_rdata),
  .w_set(w_set), .w_clr(w_clr), .w_ld_any(w_ld_any),
  .w_flag(w_flag), .w_data(w_data)
);

// File: tb/sim_capbank_regs.sv
`timescale 1ns/100ps
module sim_capbank_regs;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ld_valid = 0, ld_field = 0, ld_src = 0, ld_hi = 0;
  logic [8:0] ld_line = '0;
  logic [7:0] ld_byte = '0;
  logic cc_en_odd = 0, cc_en_even = 0, anc_take = 0;
  logic [1:0] anc_sel = '0;
  logic h_wr = 0, h_rd = 0;
  logic [7:0] h_addr = '0, h_wdata = '0;
  logic [7:0] h_rdata;
  logic soft_rst_o;

  int n_vec = 0, n_bad = 0;
  logic [7:0] m_a [4];
  logic [7:0] m_b [4];
  logic [3:0] m_flag;
  int m_cnt;

  always #2.5 clk = ~clk;

  capbank_regs u0 (.*);

  function automatic logic line_good(logic f, logic [8:0] l);
    case ({f, l})
      {1'b0, 9'd18}, {1'b0, 9'd21}, {1'b0, 9'd22},
      {1'b1, 9'd281}, {1'b1, 9'd284}, {1'b1, 9'd335}: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [7:0] exp_read(logic [7:0] a);
    if (a == 8'h1F) return {(m_cnt != 0), 3'b000, m_flag};
    if (a >= 8'h20 && a <= 8'h27) begin
      int p = (a - 8'h20) >> 1;
      return a[0] ? m_b[p] : m_a[p];
    end
    return 8'h00;
  endfunction

  function automatic string tag_of(logic [7:0] a);
    if (a == 8'h1F) return "R4/R9 ctrl";
    if (a >= 8'h20 && a <= 8'h27) return "R2 data";
    return "R11 unmapped";
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 4; i++) begin m_a[i] = 8'h80; m_b[i] = 8'h80; end
    m_flag = '0;
    m_cnt = 0;
  endtask

  // Check outputs for the inputs now applied, then advance the model one edge.
  task automatic step();
    logic acc;
    int p;
    #1;
    check(tag_of(h_addr), h_rdata, exp_read(h_addr));
    check("R9 pulse", {7'd0, soft_rst_o}, {7'd0, (m_cnt != 0)});
    @(posedge clk);
    p   = {ld_src, ld_field};
    acc = ld_valid && (ld_src || ((ld_field ? cc_en_even : cc_en_odd) && line_good(ld_field, ld_line)));
    if (m_cnt != 0) begin
      for (int i = 0; i < 4; i++) begin m_a[i] = 8'h80; m_b[i] = 8'h80; end
      m_flag = '0;
      m_cnt--;
    end else begin
      for (int i = 0; i < 4; i++)
        if ((h_rd && h_addr == 8'h21 + 8'(2*i)) || (anc_take && anc_sel == 2'(i))) m_flag[i] = 1'b0;
      if (acc) begin
        if (ld_hi) begin m_b[p] = ld_byte; m_flag[p] = 1'b1; end
        else m_a[p] = ld_byte;
      end
      if (h_wr && h_addr == 8'h1F && h_wdata[7]) m_cnt = 4;
    end
    @(negedge clk);
    ld_valid = 0; anc_take = 0; h_wr = 0; h_rd = 0;
  endtask

  task automatic load(logic f, logic s, logic hi, logic [8:0] l, logic [7:0] b);
    ld_valid = 1; ld_field = f; ld_src = s; ld_hi = hi; ld_line = l; ld_byte = b;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd4242));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset values at every address
    for (int a = 8'h1C; a <= 8'h2A; a++) begin
      h_addr = 8'(a); #1;
      check("R1 reset", h_rdata, (a >= 8'h20 && a <= 8'h27) ? 8'h80 : 8'h00);
    end
    // R3: caption with wrong line / enable off, then WSS with neither
    cc_en_odd = 1; load(0, 0, 1, 9'd19, 8'h11); h_addr = 8'h21; step();
    check("R3 bad line", h_rdata, 8'h80);
    cc_en_odd = 0; load(0, 0, 1, 9'd21, 8'h12); step();
    check("R3 enable off", h_rdata, 8'h80);
    load(1, 1, 1, 9'd5, 8'h5A); h_addr = 8'h27; step();
    check("R3 WSS any line", h_rdata, 8'h5A);
    // R5: reading A keeps flag, reading B clears
    h_addr = 8'h26; h_rd = 1; step();
    h_addr = 8'h1F; #1; check("R5 A read keeps", h_rdata, 8'h08);
    h_addr = 8'h27; h_rd = 1; step();
    h_addr = 8'h1F; #1; check("R5 B read clears", h_rdata, 8'h00);
    // R7: set and clear together
    cc_en_even = 1; load(1, 0, 1, 9'd284, 8'hC3); anc_take = 1; anc_sel = 2'd1; step();
    h_addr = 8'h1F; #1; check("R7 set wins", h_rdata, 8'h02);
    // R6: consume strobe
    anc_take = 1; anc_sel = 2'd1; step();
    #1; check("R6 consume", h_rdata, 8'h00);
    // R8: writes to data and status ignored
    h_wr = 1; h_addr = 8'h23; h_wdata = 8'h00; step();
    h_wr = 1; h_addr = 8'h1F; h_wdata = 8'h0F; step();
    h_addr = 8'h23; #1; check("R8 data write", h_rdata, 8'hC3);
    // R9/R10: pulse with retrigger and load during it
    h_wr = 1; h_addr = 8'h1F; h_wdata = 8'h80; step();
    for (int k = 0; k < 4; k++) begin
      #1; check("R9 pulse high", {7'd0, soft_rst_o}, 8'h01);
      if (k == 1) begin h_wr = 1; h_wdata = 8'h80; end
      if (k == 2) load(1, 1, 1, 9'd0, 8'h77);
      step();
    end
    #1; check("R9 pulse end", {7'd0, soft_rst_o}, 8'h00);
    h_addr = 8'h23; #1; check("R10 data reset", h_rdata, 8'h80);
    h_addr = 8'h27; #1; check("R10 load dropped", h_rdata, 8'h80);
    // Random traffic, R12 checked every cycle by step()
    for (int i = 0; i < 4000; i++) begin
      int r = $urandom_range(0, 99);
      cc_en_odd  = ($urandom_range(0, 3) != 0);
      cc_en_even = ($urandom_range(0, 3) != 0);
      if (r < 55) begin
        logic f = 1'($urandom);
        logic [8:0] l;
        case ($urandom_range(0, 3))
          0: l = f ? 9'd281 : 9'd18;
          1: l = f ? 9'd284 : 9'd21;
          2: l = f ? 9'd335 : 9'd22;
          default: l = 9'($urandom);
        endcase
        load(f, 1'($urandom), 1'($urandom), l, 8'($urandom));
      end
      if ($urandom_range(0, 5) == 0) begin anc_take = 1; anc_sel = 2'($urandom); end
      h_addr = ($urandom_range(0, 7) == 0) ? 8'($urandom) : 8'h1F + 8'($urandom_range(0, 8));
      h_rd = ($urandom_range(0, 2) == 0);
      if ($urandom_range(0, 9) == 0) begin
        h_wr = 1;
        h_wdata = ($urandom_range(0, 9) == 0) ? 8'h80 : 8'($urandom) & 8'h7F;
      end
      step();
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule